// File: doc/BRIEF.md
# LPC Peripheral DMA Request Sequencer

This block sits in an LPC peripheral and handles the request side of DMA. When local logic reports bytes waiting, the block sends a short serial message on an active-low sideband line. The message names the peripheral's channel and asks for service. The block then holds the request open until the host grants a cycle.

During a granted cycle, each byte slot is answered with a SYNC nibble. The nibble either keeps the request alive or ends it. Ending is only ever done through the SYNC code, never by withdrawing the request. After an ending code, the block keeps the sideband line quiet for a fixed holdoff before any new message.

The block also tells demand-mode operation from single-mode operation when it decides whether a host START is its grant. It never ends a 16-bit transfer on its first byte. The LAD framing other than the SYNC nibble, and the data path, belong to neighbouring logic.

Top module: `lpc_dma_req_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `ldrq_n` is 1, `sync_vld` is 0 and `busy` is 0.
- R2: When idle with `bytes_pending` non-zero, the block sends a message on `ldrq_n`, one bit per clock. The bits are: 0 (start), then `my_chan` LSB first, then 1 (active). The line then stays 1. `busy` goes high in the same cycle as the start bit, and the line is 1 whenever no message is being sent.
- R3: Once the message is sent, the request stays open until a grant is accepted. This holds even if `bytes_pending` drops to 0. No new message is sent while the request is open.
- R4: While the request is open, a `grant_start` pulse with `grant_match` high is accepted as a grant. A `grant_start` without `grant_match` is ignored, except as R5 allows.
- R5: After a grant that ended with code 1001b, a `grant_start` without `grant_match` is accepted only when `demand_mode` is 1. In single mode (`demand_mode` 0), `grant_match` is still required.
- R6: A `byte_slot` pulse during a grant gives a SYNC code on `sync_code`, with `sync_vld` high for exactly one clock, one cycle after the slot is sampled.
- R7: If `bytes_pending` is 2 or more at a slot (and the slot is not the first byte of a 16-bit grant), the code is 1001b. The request then stays open without a new message.
- R8: If `bytes_pending` is 0 or 1 at a slot that is not the first byte of a 16-bit grant, the code is an ending code: 0000b when `data_err` is 0, and 1010b when `data_err` is 1.
- R9: On the first byte of a grant taken with `grant_wide` high, the code is always 1001b. A second `byte_slot` in the same grant is then answered under R7/R8.
- R10: After an ending code, no message starts for eight clocks after the cycle in which the code is shown. If `bytes_pending` is non-zero, the start bit appears exactly eight clocks after that cycle.
- R11: `busy` stays high through the holdoff. When the holdoff ends with `bytes_pending` at 0, `busy` falls and no message is sent.
- R12: `byte_slot` pulses outside a granted cycle produce no SYNC code and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | LPC clock |
| rst | input | 1 | Synchronous active-high reset |
| my_chan | input | CH_W | DMA channel number this peripheral uses |
| bytes_pending | input | CNT_W | Bytes the local side still has to move |
| demand_mode | input | 1 | 1 = demand mode, 0 = single mode |
| data_err | input | 1 | Local data error; selects the error form of the ending code |
| grant_start | input | 1 | One-clock pulse: host started a DMA cycle |
| grant_match | input | 1 | The started cycle names this peripheral's channel |
| grant_wide | input | 1 | The started cycle is a 16-bit transfer |
| byte_slot | input | 1 | One-clock pulse: the host awaits SYNC for one byte |
| ldrq_n | output | 1 | Serial request line, idle high |
| sync_vld | output | 1 | `sync_code` is valid this clock |
| sync_code | output | 4 | SYNC nibble for the byte |
| busy | output | 1 | Request open, grant in progress or holdoff running |

## Verification
The SYNC choice is tried with pending counts of 3, 2, 1 and 0, with and without `data_err`, on 8-bit and 16-bit grants. These runs separate the "more" code from both ending codes, and show that the first-byte rule of a wide grant overrides a low count. Unmatched STARTs are sent in single mode and in demand mode after a "more" code. This shows that only demand mode takes such a START as its grant. The holdoff is measured in clocks from the ending code to the next start bit, and is also run with no bytes pending, to show that `busy` then falls without a message.

// File: rtl/lpc_dreq_pkg.sv
package lpc_dreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MSG,
        ST_WAIT,
        ST_XFER,
        ST_HOLD
    } seq_state_e;

    localparam logic [3:0] SYNC_DONE     = 4'b0000;
    localparam logic [3:0] SYNC_DONE_ERR = 4'b1010;
    localparam logic [3:0] SYNC_MORE     = 4'b1001;

    typedef struct packed {
        logic [3:0] code;
        logic       last;
    } sync_pick_t;

    function automatic sync_pick_t pick_sync(input logic few_left,
                                             input logic first_wide,
                                             input logic err);
        sync_pick_t p;
        if (first_wide || !few_left) begin
            p.code = SYNC_MORE;
            p.last = 1'b0;
        end else begin
            p.code = err ? SYNC_DONE_ERR : SYNC_DONE;
            p.last = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/lpc_dreq_msg.sv
module lpc_dreq_msg #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [CH_W-1:0] chan,
    output logic            line,
    output logic            done
);
    localparam int IW = $clog2(CH_W + 2);
    localparam logic [IW-1:0] LAST_I = IW'(CH_W + 1);

    logic            act;
    logic [IW-1:0]   idx;
    logic [CH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            idx <= '0;
            sh  <= '0;
        end else if (go) begin
            act <= 1'b1;
            idx <= '0;
            sh  <= chan;
        end else if (act) begin
            if (idx == LAST_I) begin
                act <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
                if (idx != '0) sh <= sh >> 1;
            end
        end
    end

    always_comb begin
        if (!act)              line = 1'b1;
        else if (idx == '0)    line = 1'b0;
        else if (idx == LAST_I) line = 1'b1;
        else                   line = sh[0];
    end

    assign done = act && (idx == LAST_I);

endmodule

// File: rtl/lpc_dreq_gap.sv
module lpc_dreq_gap #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] TOP = CW'(GAP - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= TOP;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lpc_dreq_sync.sv
module lpc_dreq_sync
    import lpc_dreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  sync_pick_t pick,
    output logic       vld,
    output logic [3:0] code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            code <= SYNC_DONE;
        end else begin
            vld <= fire;
            if (fire) code <= pick.code;
        end
    end

    AST_SYNC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        vld |-> (code == SYNC_MORE || code == SYNC_DONE || code == SYNC_DONE_ERR)); // R8

endmodule

// File: rtl/lpc_dma_req_seq.sv
module lpc_dma_req_seq
    import lpc_dreq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 8,
    parameter int GAP   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  my_chan,
    input  logic [CNT_W-1:0] bytes_pending,
    input  logic             demand_mode,
    input  logic             data_err,
    input  logic             grant_start,
    input  logic             grant_match,
    input  logic             grant_wide,
    input  logic             byte_slot,
    output logic             ldrq_n,
    output logic             sync_vld,
    output logic [3:0]       sync_code,
    output logic             busy
);
    localparam int SW = $clog2(GAP + 1) + 1;

    seq_state_e state;
    logic       cont_q;
    logic       wide_q;
    logic       slot2_q;

    logic       have_data;
    logic       few_left;
    logic       first_wide;
    logic       accept;
    logic       go;
    logic       msg_done;
    logic       gap_load;
    logic       gap_exp;
    logic       fire;
    sync_pick_t pick;

    assign have_data  = (bytes_pending != '0);
    assign few_left   = (bytes_pending <= CNT_W'(1));
    assign first_wide = wide_q && !slot2_q;
    assign pick       = pick_sync(few_left, first_wide, data_err);
    assign accept     = (state == ST_WAIT) && grant_start &&
                        (grant_match || (cont_q && demand_mode));
    assign fire       = (state == ST_XFER) && byte_slot;
    assign gap_load   = fire && pick.last;
    assign go         = have_data &&
                        ((state == ST_IDLE) || (state == ST_HOLD && gap_exp));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cont_q  <= 1'b0;
            wide_q  <= 1'b0;
            slot2_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) state <= ST_MSG;
                ST_MSG: if (msg_done) begin
                    state  <= ST_WAIT;
                    cont_q <= 1'b0;
                end
                ST_WAIT: if (accept) begin
                    state   <= ST_XFER;
                    wide_q  <= grant_wide;
                    slot2_q <= 1'b0;
                end
                ST_XFER: if (fire) begin
                    if (pick.last) begin
                        state <= ST_HOLD;
                    end else if (first_wide) begin
                        slot2_q <= 1'b1;
                    end else begin
                        state  <= ST_WAIT;
                        cont_q <= 1'b1;
                    end
                end
                ST_HOLD: if (gap_exp) state <= go ? ST_MSG : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    lpc_dreq_msg #(.CH_W(CH_W)) u_msg (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .chan (my_chan),
        .line (ldrq_n),
        .done (msg_done)
    );

    lpc_dreq_gap #(.GAP(GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_exp)
    );

    lpc_dreq_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .pick (pick),
        .vld  (sync_vld),
        .code (sync_code)
    );

    assign busy = (state != ST_IDLE);

    // cycles since an ending code was shown, saturating
    logic [SW-1:0] since_end;
    always_ff @(posedge clk) begin
        if (rst)                                   since_end <= SW'(GAP);
        else if (sync_vld && sync_code != SYNC_MORE) since_end <= '0;
        else if (since_end < SW'(GAP))             since_end <= since_end + 1'b1;
    end

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state != ST_MSG) |-> ldrq_n); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_XFER)); // R3

    AST_NO_END_FIRST: assert property (@(posedge clk) disable iff (rst)
        (fire && first_wide) |=> (sync_vld && sync_code == SYNC_MORE)); // R9

    AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(ldrq_n) |-> (since_end >= SW'(GAP - 1))); // R10

    AST_SYNC_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
        fire |=> sync_vld); // R6

endmodule

// File: tb/lpc_dma_req_seq_tb.sv
`timescale 1ns/1ps
module lpc_dma_req_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] my_chan = 3'd5;
    logic [7:0] bytes_pending = 8'd0;
    logic       demand_mode = 1'b0;
    logic       data_err = 1'b0;
    logic       grant_start = 1'b0;
    logic       grant_match = 1'b0;
    logic       grant_wide = 1'b0;
    logic       byte_slot = 1'b0;
    logic       ldrq_n, sync_vld, busy;
    logic [3:0] sync_code;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lpc_dma_req_seq u_dut (
        .clk(clk), .rst(rst), .my_chan(my_chan), .bytes_pending(bytes_pending),
        .demand_mode(demand_mode), .data_err(data_err), .grant_start(grant_start),
        .grant_match(grant_match), .grant_wide(grant_wide), .byte_slot(byte_slot),
        .ldrq_n(ldrq_n), .sync_vld(sync_vld), .sync_code(sync_code), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase = 0;   // 0 idle,1 message,2 waiting,3 granted,4 holdoff
    int m_idx = 0, m_hold = 0;
    bit m_cont = 0, m_wide = 0, m_second = 0, m_vld = 0, m_first = 0;
    int m_code = 0;
    logic [2:0] m_ch = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0; m_vld = 0; m_code = 0; m_cont = 0;
        end else begin
            m_vld = 0;
            case (m_phase)
                0: if (bytes_pending != 0) begin m_phase = 1; m_idx = 0; m_ch = my_chan; end
                1: if (m_idx == 4) begin m_phase = 2; m_cont = 0; end else m_idx++;
                2: if (grant_start && (grant_match || (m_cont && demand_mode))) begin
                       m_phase = 3; m_wide = grant_wide; m_second = 0;
                   end
                3: if (byte_slot) begin
                       m_vld = 1;
                       m_first = m_wide && !m_second;
                       if (m_first || bytes_pending >= 2) m_code = 9;
                       else m_code = data_err ? 10 : 0;
                       if (m_code != 9) begin m_phase = 4; m_hold = 7; end
                       else if (m_first) m_second = 1;
                       else begin m_phase = 2; m_cont = 1; end
                   end
                4: if (m_hold == 0) begin
                       if (bytes_pending != 0) begin m_phase = 1; m_idx = 0; m_ch = my_chan; end
                       else m_phase = 0;
                   end else m_hold--;
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_line;
            exp_line = 1;
            if (m_phase == 1) exp_line = (m_idx == 0) ? 0 : (m_idx == 4) ? 1 : int'(m_ch[m_idx-1]);
            chk(m_phase == 1 ? "R2 line" : (m_phase == 4 ? "R10 line" : "R3 line"),
                int'(ldrq_n), exp_line);
            chk("R6 sync_vld", int'(sync_vld), int'(m_vld));
            if (m_vld) chk(m_code != 9 ? "R8 code" : (m_first ? "R9 code" : "R7 code"),
                           int'(sync_code), m_code);
            chk("R11 busy", int'(busy), int'(m_phase != 0));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_grant(input logic match, input logic wide);
        grant_start = 1; grant_match = match; grant_wide = wide;
        @(negedge clk);
        grant_start = 0; grant_match = 0; grant_wide = 0;
    endtask

    task automatic pulse_slot();
        byte_slot = 1;
        @(negedge clk);
        byte_slot = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        while (cyc < 20000) @(negedge clk);
        chk("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        logic [4:0] bits;
        int k;
        tick(4);
        chk("R1 ldrq_n", int'(ldrq_n), 1);
        chk("R1 sync_vld", int'(sync_vld), 0);
        chk("R1 busy", int'(busy), 0);
        rst = 0;
        tick(1);
        chk("R1 busy after release", int'(busy), 0);

        // message for channel 5, single mode
        bytes_pending = 3;
        k = 0;
        while (ldrq_n && k < 20) begin tick(1); k++; end
        bits[0] = ldrq_n;
        chk("R2 busy with start bit", int'(busy), 1);
        for (int i = 1; i < 5; i++) begin tick(1); bits[i] = ldrq_n; end
        chk("R2 message bits", int'(bits), int'({1'b1, 3'd5, 1'b0}));
        tick(3);

        pulse_slot();
        chk("R12 slot while waiting", int'(sync_vld), 0);
        pulse_grant(0, 0);
        pulse_slot();
        chk("R4 unmatched start ignored", int'(sync_vld), 0);
        pulse_grant(1, 0);
        pulse_slot();
        chk("R6 sync valid", int'(sync_vld), 1);
        chk("R7 more code", int'(sync_code), 9);
        tick(1);
        chk("R6 one clock only", int'(sync_vld), 0);

        bytes_pending = 1;
        pulse_grant(0, 0);
        pulse_slot();
        chk("R5 single mode needs match", int'(sync_vld), 0);
        pulse_grant(1, 0);
        pulse_slot();
        chk("R8 done code", int'(sync_code), 0);
        bytes_pending = 2;
        k = 0;
        while (ldrq_n && k < 30) begin tick(1); k++; end
        chk("R10 holdoff clocks", k, 8);
        tick(8);

        demand_mode = 1;
        pulse_grant(1, 0);
        pulse_slot();
        chk("R7 more in demand", int'(sync_code), 9);
        bytes_pending = 1; data_err = 1;
        pulse_grant(0, 0);
        pulse_slot();
        chk("R5 demand accepts unmatched", int'(sync_vld), 1);
        chk("R8 error done code", int'(sync_code), 10);
        bytes_pending = 0; data_err = 0;
        tick(3);
        chk("R11 busy in holdoff", int'(busy), 1);
        tick(8);
        chk("R11 idle after holdoff", int'(busy), 0);
        chk("R11 no message", int'(ldrq_n), 1);

        // 16-bit grants on channel 2
        my_chan = 3'd2; demand_mode = 0;
        bytes_pending = 1;
        tick(10);
        bytes_pending = 0;
        tick(5);
        chk("R3 request held", int'(busy), 1);
        chk("R3 no new message", int'(ldrq_n), 1);
        bytes_pending = 1;
        pulse_grant(1, 1);
        pulse_slot();
        chk("R9 first wide byte", int'(sync_code), 9);
        pulse_slot();
        chk("R8 second wide byte", int'(sync_code), 0);
        bytes_pending = 3;
        tick(20);
        pulse_grant(1, 1);
        pulse_slot();
        chk("R9 first byte more", int'(sync_code), 9);
        pulse_slot();
        chk("R7 second byte more", int'(sync_code), 9);
        pulse_slot();
        chk("R12 slot after grant", int'(sync_vld), 0);
        tick(4);
        finish_run();
    end
endmodule